// File: doc/BRIEF.md
# Four-State Bus Cycle Sequencer

This block runs one external memory transfer at a time on a parallel bus. A requester offers a 20-bit address, a direction bit and write data. When the sequencer is idle it takes the request and walks through four fixed clock states. In the first state it places the address on the bus and pulses an address-valid strobe. The second state pulls the address off and raises the read or write strobe. The third state is where data moves across the bus. The fourth state closes the cycle and pulses `done`. On a read, the captured word is shown on `rsp_rdata` while `done` is high.

The slave paces the transfer with `bus_ready`. That input is looked at only on the clock edge that leaves T3 or a wait state. While it is low, the sequencer adds wait states (TW) between T3 and T4. After T4 the sequencer spends one cycle in IDLE. A request that is still held then starts T1 on the next clock.

States: IDLE, T1, T2, T3, TW, T4. Transitions: IDLE→T1 when `req_valid` is high. T1→T2 and T2→T3 always. T3→T4 and TW→T4 when `bus_ready` is high. T3→TW and TW→TW when `bus_ready` is low. T4→IDLE always.

Top module: `bus_cycle_seq`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all of these are 0 whatever the request inputs do: `busy`, `done`, `bus_ale`, `bus_rd`, `bus_wr`, `bus_wdata_oe`, `bus_rdata_ie`, `bus_addr` and `bus_wdata`.
- R2: If `req_valid` is high at a clock edge while `busy` is low, the next cycle is T1. `busy` stays high from T1 through T4 and is low in the cycle after T4.
- R3: `bus_ale` is high only in T1. `bus_addr` equals the accepted address in T1 and is zero in every other cycle.
- R4: For a read (`req_write`=0), `bus_rd` is high in T2, T3 and every TW. For a write (`req_write`=1), `bus_wr` is high in those same cycles. The two strobes are never high together.
- R5: For a write, `bus_wdata_oe` is high in T2, T3, every TW and T4, and `bus_wdata` equals the accepted write data in those cycles. In all other cycles `bus_wdata` is zero. For a read, `bus_rdata_ie` is high in T3 and every TW.
- R6: `bus_ready` is sampled only on the edge leaving T3 or TW. A low value there adds one TW; a high value moves to T4. The value of `bus_ready` in IDLE, T1, T2 and T4 has no effect.
- R7: On a read, `bus_rdata` is captured on the edge where `bus_ready` is high in T3 or TW. The captured word appears on `rsp_rdata` during T4.
- R8: `done` is high for exactly one cycle, in T4, for every read and every write.
- R9: After T4 there is exactly one IDLE cycle. A request held through that cycle starts T1 on the clock after it.
- R10: Request inputs that change while `busy` is high do not alter the address, direction or data of the transfer in progress, and do not start a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_write | input | 1 | Direction: 1 means write, 0 means read |
| req_addr | input | ADDR_W (20) | Physical transfer address |
| req_wdata | input | DATA_W (16) | Write data |
| busy | output | 1 | High from T1 through T4 |
| done | output | 1 | One-cycle pulse in T4 |
| rsp_rdata | output | DATA_W | Captured read word, valid with `done` on reads |
| bus_addr | output | ADDR_W | Address lines, driven in T1 only |
| bus_ale | output | 1 | Address-valid strobe, T1 only |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DATA_W | Write data lines |
| bus_wdata_oe | output | 1 | Write data drive enable |
| bus_rdata_ie | output | 1 | Read data receive enable |
| bus_rdata | input | DATA_W | Read data from slave |
| bus_ready | input | 1 | Slave ready; low inserts wait states |

## Verification
Two situations are hard to reach from the ports. The first is the edge where `bus_ready` rises after a long run of wait states. The second is a request held across T4, so that the IDLE gap and the next T1 follow directly. The driver sets `bus_ready` high only in the last of a random number of wait cycles. It puts the inverted word on `bus_rdata` in every earlier wait cycle, so a capture one edge early or late shows up as a wrong `rsp_rdata`. It also starts the next transfer during T4. In T1, T2 and the data states it changes the request inputs and toggles `bus_ready` at random. This shows that values outside the sampling points leave the transfer unchanged.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Bus cycle states; TW is the ready-driven wait state between T3 and T4.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    function automatic logic in_data_phase(input bus_state_e s);
        return (s == ST_T3) || (s == ST_TW);
    endfunction

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_ready,
    output bus_state_e state_q,
    output logic       accept,
    output logic       xfer_end
);

    bus_state_e state_d;

    // A request is taken only from IDLE.
    assign accept   = (state_q == ST_IDLE) && req_valid;
    // The edge that ends the data phase: ready seen in T3 or TW.
    assign xfer_end = in_data_phase(state_q) && bus_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = ST_T1;
                end
            end
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3,
            ST_TW: begin
                if (bus_ready) begin
                    state_d = ST_T4;
                end else begin
                    state_d = ST_TW;
                end
            end
            ST_T4:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              xfer_end,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              op_write_q,
    output logic [ADDR_W-1:0] op_addr_q,
    output logic [DATA_W-1:0] op_wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Transfer attributes: loaded only when a request is accepted,
    // so request inputs are ignored for the rest of the cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_write_q <= 1'b0;
            op_addr_q  <= '0;
            op_wdata_q <= '0;
        end else if (accept) begin
            op_write_q <= req_write;
            op_addr_q  <= req_addr;
            op_wdata_q <= req_wdata;
        end
    end

    // Read capture on the edge that leaves T3 or the final wait state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (xfer_end && !op_write_q) begin
            rdata_q <= bus_rdata;
        end
    end

endmodule

// File: rtl/bcs_strobes.sv
module bcs_strobes
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  bus_state_e        state_q,
    input  logic              op_write_q,
    input  logic [ADDR_W-1:0] op_addr_q,
    input  logic [DATA_W-1:0] op_wdata_q,
    output logic              busy,
    output logic              done,
    output logic              bus_ale,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_wdata_oe,
    output logic              bus_rdata_ie,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    always_comb begin
        busy         = 1'b0;
        done         = 1'b0;
        bus_ale      = 1'b0;
        bus_rd       = 1'b0;
        bus_wr       = 1'b0;
        bus_wdata_oe = 1'b0;
        bus_rdata_ie = 1'b0;
        bus_addr     = '0;
        bus_wdata    = '0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_T1: begin
                busy     = 1'b1;
                bus_ale  = 1'b1;
                bus_addr = op_addr_q;
            end
            ST_T2: begin
                busy         = 1'b1;
                bus_rd       = !op_write_q;
                bus_wr       = op_write_q;
                bus_wdata_oe = op_write_q;
            end
            ST_T3,
            ST_TW: begin
                busy         = 1'b1;
                bus_rd       = !op_write_q;
                bus_wr       = op_write_q;
                bus_wdata_oe = op_write_q;
                bus_rdata_ie = !op_write_q;
            end
            ST_T4: begin
                busy         = 1'b1;
                done         = 1'b1;
                bus_wdata_oe = op_write_q;
            end
            default: begin
            end
        endcase
        if (bus_wdata_oe) begin
            bus_wdata = op_wdata_q;
        end
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ale,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    output logic              bus_rdata_ie,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);

    bus_state_e        state_q;
    logic              accept;
    logic              xfer_end;
    logic              op_write_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [DATA_W-1:0] op_wdata_q;

    bcs_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .state_q   (state_q),
        .accept    (accept),
        .xfer_end  (xfer_end)
    );

    bcs_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .xfer_end   (xfer_end),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .bus_rdata  (bus_rdata),
        .op_write_q (op_write_q),
        .op_addr_q  (op_addr_q),
        .op_wdata_q (op_wdata_q),
        .rdata_q    (rsp_rdata)
    );

    bcs_strobes #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_stb (
        .state_q      (state_q),
        .op_write_q   (op_write_q),
        .op_addr_q    (op_addr_q),
        .op_wdata_q   (op_wdata_q),
        .busy         (busy),
        .done         (done),
        .bus_ale      (bus_ale),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata_oe (bus_wdata_oe),
        .bus_rdata_ie (bus_rdata_ie),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata)
    );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ale,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_wdata_oe,
    input logic              bus_rdata_ie,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_ready
);

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> bus_ale);

    p_ale_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> busy);

    p_addr_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ale |-> (bus_addr == '0));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    p_ale_to_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> (bus_rd || bus_wr));

    p_wr_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> bus_wdata_oe);

    p_ie_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_ie |-> bus_rd);

    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_ie && !bus_ready) |=> bus_rdata_ie);

    p_ready_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_ie && bus_ready) |=> done);

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata_ie && bus_ready) |=> (rsp_rdata == $past(bus_rdata)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> !bus_ale);

endmodule

bind bus_cycle_seq bcs_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .busy         (busy),
    .done         (done),
    .rsp_rdata    (rsp_rdata),
    .bus_addr     (bus_addr),
    .bus_ale      (bus_ale),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata_oe (bus_wdata_oe),
    .bus_rdata_ie (bus_rdata_ie),
    .bus_rdata    (bus_rdata),
    .bus_ready    (bus_ready)
);

// File: tb/bus_cycle_seq_tb.sv
module bus_cycle_seq_tb;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          busy, done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_ale, bus_rd, bus_wr, bus_wdata_oe, bus_rdata_ie;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_ready;

    always #5 clk = ~clk;

    bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_ale(bus_ale),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_wdata_oe(bus_wdata_oe), .bus_rdata_ie(bus_rdata_ie),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    typedef struct {
        bit            busy, ale, rd, wr, woe, rie, done;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        bit            chk_rdata;
        logic [DW-1:0] rdata;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   after_t4 = 0;
    bit   finished = 0;

    function automatic exp_t idle_e(input string tag);
        exp_t e;
        e.busy = 0; e.ale = 0; e.rd = 0; e.wr = 0; e.woe = 0; e.rie = 0;
        e.done = 0; e.addr = '0; e.wdata = '0; e.chk_rdata = 0; e.rdata = '0;
        e.tag = tag;
        return e;
    endfunction

    task automatic chk(input string req, input string fld, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s %s [%s] at %0t: actual %0h expected %0h",
                     req, fld, tag, $time, act, expv);
        end
    endtask

    // Random request noise while busy (R10) and ready noise outside sampling (R6).
    task automatic noise();
        req_valid = 1'($urandom());
        req_write = 1'($urandom());
        req_addr  = AW'($urandom());
        req_wdata = DW'($urandom());
        bus_ready = 1'($urandom());
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0;
            bus_ready = 1'($urandom());
            bus_rdata = DW'($urandom());
            exp_q.push_back(idle_e("R9 idle gap"));
        end
        after_t4 = 0;
    endtask

    // Driver: one transfer with a given count of wait states.
    task automatic bus_txn(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input logic [DW-1:0] rd, input int waits);
        exp_t e;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        bus_ready = 1'($urandom());
        if (after_t4) begin
            exp_q.push_back(idle_e("R9 one idle after T4"));
            @(negedge clk);
            bus_ready = 1'($urandom());
        end
        e = idle_e("R2 T1"); e.busy = 1; e.ale = 1; e.addr = a;
        exp_q.push_back(e);
        @(negedge clk);
        noise();
        e = idle_e("R10 T2 with request noise"); e.busy = 1; e.rd = !wr; e.wr = wr;
        e.woe = wr; e.wdata = wr ? wd : '0;
        exp_q.push_back(e);
        @(negedge clk);
        noise();
        e.tag = "R4 T3"; e.rie = !wr;
        exp_q.push_back(e);
        for (int i = 0; i <= waits; i++) begin
            @(negedge clk);
            noise();
            req_valid = 1'($urandom()) & (i != waits);
            bus_ready = (i == waits);
            bus_rdata = (i == waits) ? rd : ~rd;
            if (i < waits) begin
                e.tag = "R6 wait state";
                exp_q.push_back(e);
            end else begin
                e = idle_e("R7 R8 T4"); e.busy = 1; e.done = 1; e.woe = wr;
                e.wdata = wr ? wd : '0; e.chk_rdata = !wr; e.rdata = rd;
                exp_q.push_back(e);
            end
        end
        after_t4 = 1;
    endtask

    // Monitor: pops one expected item per cycle, sampled after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R2", "busy",  e.tag, 32'(busy),         32'(e.busy));
                chk("R3", "ale",   e.tag, 32'(bus_ale),      32'(e.ale));
                chk("R3", "addr",  e.tag, 32'(bus_addr),     32'(e.addr));
                chk("R4", "rd",    e.tag, 32'(bus_rd),       32'(e.rd));
                chk("R4", "wr",    e.tag, 32'(bus_wr),       32'(e.wr));
                chk("R5", "woe",   e.tag, 32'(bus_wdata_oe), 32'(e.woe));
                chk("R5", "wdata", e.tag, 32'(bus_wdata),    32'(e.wdata));
                chk("R5", "rie",   e.tag, 32'(bus_rdata_ie), 32'(e.rie));
                chk("R8", "done",  e.tag, 32'(done),         32'(e.done));
                if (e.chk_rdata) begin
                    chk("R7", "rsp_rdata", e.tag, 32'(rsp_rdata), 32'(e.rdata));
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 0; req_valid = 1; req_write = 1; req_addr = 20'hABCDE;
        req_wdata = 16'h1234; bus_rdata = '0; bus_ready = 0;
        // R1: request held during reset is ignored.
        repeat (3) begin
            @(negedge clk);
            exp_q.push_back(idle_e("R1 in reset"));
        end
        @(negedge clk);
        rst_n = 1; req_valid = 0;
        exp_q.push_back(idle_e("R1 after reset"));
        idle_cycles(2);
        bus_txn(0, 20'hFFFFF, 16'h0, 16'hBEEF, 0);   // read, no wait
        idle_cycles(1);
        bus_txn(1, 20'h00001, 16'hA5A5, 16'h0, 3);   // write, 3 waits
        bus_txn(0, 20'h12345, 16'h0, 16'h5A5A, 5);   // back-to-back read (R9)
        bus_txn(1, 20'h80000, 16'hFFFF, 16'h0, 0);   // back-to-back write
        for (int k = 0; k < 40; k++) begin
            bus_txn(1'($urandom()), AW'($urandom()), DW'($urandom()),
                    DW'($urandom()), int'($urandom_range(0, 7)));
            if ($urandom_range(0, 2) == 0) idle_cycles(int'($urandom_range(1, 2)));
        end
        idle_cycles(2);
        wait (exp_q.size() == 0);
        @(negedge clk);
        finish_run();
    end

endmodule